// File: doc/BRIEF.md
# Self-Test Frame Launch Controller

This block sits between a simple register bus and the link layer of a two-port serial storage controller. Software writes one 32-bit control/status word to choose six test parameters and to set a start bit for port 0 or port 1. On the 0-to-1 transition of a start bit, the block issues a single launch request to the link layer. The request carries the port number and the parameter field. It is issued only when the selected port reports a device that is present and ready.

The link layer answers each launch with an OK or an error completion. The block records the answer in one of two sticky status flags, which software clears by writing 1. A port whose test ended in OK is locked against further launches until its port-enable input goes low and then returns high. After an error, software retries by clearing the start bit and setting it again.

Only one test may be outstanding at a time. If both start bits rise in the same write and both ports are eligible, port 0 is served and the port 1 edge is dropped.

Top module: `bist_launch_ctrl`

## Requirements
- R1: Bit 11 of the control word is the OK flag. It sets on the clock edge at which `cpl_ok` is sampled high while a launch is outstanding, and writing 1 to bit 11 clears it.
- R2: Bit 10 is the error flag. It sets on the edge at which `cpl_err` is sampled high (with `cpl_ok` low) while a launch is outstanding, and writing 1 to bit 10 clears it.
- R3: Bit 8 is the port 0 start bit and bit 9 is the port 1 start bit. A write that changes a start bit from 0 to 1 produces `launch_valid` high for exactly one cycle, in the cycle after the write, with `launch_port` set to the port number. Rewriting a start bit that is already 1 launches nothing.
- R4: A rising start bit is ignored, with no launch and no outstanding test, when `dev_ready` for that port is low in the write cycle.
- R5: Bits 7:2 are a read/write parameter field. `launch_param` equals that field, and it is the same for either port.
- R6: After an OK completion on a port, rising edges of that port's start bit are ignored until its `port_en` input has been low and then high again.
- R7: After an error completion, clearing and then setting the start bit launches again, and this can repeat without limit.
- R8: Bits 31:12 and 1:0 always read as 0, whatever is written to them. All bits read 0 after reset.
- R9: When a flag-setting completion and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R10: At most one launch is outstanding. A start-bit rising edge while a launch is outstanding is ignored, and a completion that arrives while no launch is outstanding changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Current control/status word |
| dev_ready | input | 2 | Per port: device present and not in a low-power state |
| port_en | input | 2 | Per port: port enable, toggled low then high to unlock |
| launch_valid | output | 1 | One-cycle launch request to the link layer |
| launch_port | output | 1 | Port number of the launch |
| launch_param | output | 6 | Test parameter field for the launch |
| cpl_ok | input | 1 | Link completion with OK status |
| cpl_err | input | 1 | Link completion with error status |

## Verification
Two functions can act in the same cycle: a completion setting a status flag, and a software write-1 clearing that same flag. The bench provokes this by asserting `cpl_err` in the very cycle that a write carries 1 in bit 10. It then requires the error flag to read back as 1. A second collision is a start-bit rising edge that arrives while a launch is still outstanding. The scoreboard judges it by finding no launch for which it has no expected entry.

// File: rtl/bist_launch_pkg.sv
package bist_launch_pkg;
    localparam int N_PORTS   = 2;
    localparam int PARAM_W   = 6;
    localparam int WORD_W    = 32;
    localparam int OK_BIT    = 11;
    localparam int ERR_BIT   = 10;
    localparam int START_LSB = 8;
    localparam int PARAM_LSB = 2;
    localparam int PORT_W    = $clog2(N_PORTS);

    typedef struct packed {
        logic                 flag_ok;
        logic                 flag_err;
        logic [N_PORTS-1:0]   start;
        logic [PARAM_W-1:0]   param;
        logic                 pend;
        logic [PORT_W-1:0]    pend_port;
        logic                 launch;
        logic [PORT_W-1:0]    launch_port;
    } ctl_state_t;
endpackage

// File: rtl/bist_port_lock.sv
module bist_port_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic success,
    input  logic port_en,
    output logic locked
);
    typedef struct packed {
        logic en;
        logic lock;
    } lock_state_t;

    lock_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.en = port_en;
        if (success)
            s_d.lock = 1'b1;
        else if (port_en && !s_q.en)
            s_d.lock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign locked = s_q.lock;
endmodule

// File: rtl/bist_launch_sel.sv
module bist_launch_sel
    import bist_launch_pkg::*;
(
    input  logic [N_PORTS-1:0] rise,
    input  logic [N_PORTS-1:0] ready,
    input  logic [N_PORTS-1:0] locked,
    input  logic               busy,
    output logic               fire,
    output logic [PORT_W-1:0]  fire_port
);
    logic [N_PORTS-1:0] eligible;

    genvar g;
    generate
        for (g = 0; g < N_PORTS; g++) begin : g_elig
            assign eligible[g] = rise[g] & ready[g] & ~locked[g] & ~busy;
        end
    endgenerate

    always_comb begin
        fire      = 1'b0;
        fire_port = '0;
        for (int p = N_PORTS - 1; p >= 0; p--) begin
            if (eligible[p]) begin
                fire      = 1'b1;
                fire_port = PORT_W'(p);
            end
        end
    end
endmodule

// File: rtl/bist_launch_ctrl.sv
module bist_launch_ctrl
    import bist_launch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [WORD_W-1:0]   reg_wr_data,
    output logic [WORD_W-1:0]   reg_rd_data,
    input  logic [N_PORTS-1:0]  dev_ready,
    input  logic [N_PORTS-1:0]  port_en,
    output logic                launch_valid,
    output logic [PORT_W-1:0]   launch_port,
    output logic [PARAM_W-1:0]  launch_param,
    input  logic                cpl_ok,
    input  logic                cpl_err
);
    ctl_state_t s_d, s_q;

    logic [N_PORTS-1:0] wr_start;
    logic [N_PORTS-1:0] rise;
    logic [N_PORTS-1:0] locked;
    logic [N_PORTS-1:0] success;
    logic               fire;
    logic [PORT_W-1:0]  fire_port;
    logic               done_ok;
    logic               done_err;
    logic               pending;

    assign wr_start = reg_wr_data[START_LSB +: N_PORTS];
    assign rise     = reg_wr_en ? (wr_start & ~s_q.start) : '0;
    assign pending  = s_q.pend;
    assign done_ok  = cpl_ok & s_q.pend;
    assign done_err = cpl_err & ~cpl_ok & s_q.pend;

    bist_launch_sel i_sel (
        .rise      (rise),
        .ready     (dev_ready),
        .locked    (locked),
        .busy      (s_q.pend),
        .fire      (fire),
        .fire_port (fire_port)
    );

    genvar g;
    generate
        for (g = 0; g < N_PORTS; g++) begin : g_lock
            assign success[g] = done_ok && (s_q.pend_port == PORT_W'(g));
            bist_port_lock i_lock (
                .clk     (clk),
                .rst_n   (rst_n),
                .success (success[g]),
                .port_en (port_en[g]),
                .locked  (locked[g])
            );
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.launch = 1'b0;

        if (reg_wr_en) begin
            s_d.start = wr_start;
            s_d.param = reg_wr_data[PARAM_LSB +: PARAM_W];
            if (reg_wr_data[OK_BIT])
                s_d.flag_ok = 1'b0;
            if (reg_wr_data[ERR_BIT])
                s_d.flag_err = 1'b0;
        end

        if (done_ok)
            s_d.flag_ok = 1'b1;
        if (done_err)
            s_d.flag_err = 1'b1;

        if (done_ok || done_err)
            s_d.pend = 1'b0;

        if (fire) begin
            s_d.pend        = 1'b1;
            s_d.pend_port   = fire_port;
            s_d.launch      = 1'b1;
            s_d.launch_port = fire_port;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    always_comb begin
        reg_rd_data                          = '0;
        reg_rd_data[OK_BIT]                  = s_q.flag_ok;
        reg_rd_data[ERR_BIT]                 = s_q.flag_err;
        reg_rd_data[START_LSB +: N_PORTS]    = s_q.start;
        reg_rd_data[PARAM_LSB +: PARAM_W]    = s_q.param;
    end

    assign launch_valid = s_q.launch;
    assign launch_port  = s_q.launch_port;
    assign launch_param = s_q.param;
endmodule

// File: rtl/bist_launch_chk.sv
module bist_launch_chk
    import bist_launch_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cpl_ok,
    input logic                cpl_err,
    input logic [N_PORTS-1:0]  dev_ready,
    input logic                launch_valid,
    input logic [PORT_W-1:0]   launch_port,
    input logic [WORD_W-1:0]   reg_rd_data,
    input logic                pending,
    input logic [N_PORTS-1:0]  locked
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |=> !launch_valid);

    a_r4_ready_p0: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_port == 0) |-> $past(dev_ready[0]));

    a_r4_ready_p1: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_port == 1) |-> $past(dev_ready[1]));

    a_r6_locked_p0: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_port == 0) |-> !$past(locked[0]));

    a_r6_locked_p1: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_port == 1) |-> !$past(locked[1]));

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> !$past(pending));

    a_r1_ok_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && cpl_ok) |=> reg_rd_data[OK_BIT]);

    a_r2_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && cpl_err && !cpl_ok) |=> reg_rd_data[ERR_BIT]);

    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[WORD_W-1:OK_BIT+1] == '0) && (reg_rd_data[PARAM_LSB-1:0] == '0));
endmodule

bind bist_launch_ctrl bist_launch_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpl_ok       (cpl_ok),
    .cpl_err      (cpl_err),
    .dev_ready    (dev_ready),
    .launch_valid (launch_valid),
    .launch_port  (launch_port),
    .reg_rd_data  (reg_rd_data),
    .pending      (pending),
    .locked       (locked)
);

// File: tb/test_bist_launch_ctrl.sv
module test_bist_launch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic [1:0]  dev_ready = 2'b11;
    logic [1:0]  port_en = 2'b11;
    logic        launch_valid;
    logic [0:0]  launch_port;
    logic [5:0]  launch_param;
    logic        cpl_ok = 1'b0;
    logic        cpl_err = 1'b0;

    int tests = 0;
    int fails = 0;
    logic [6:0] exp_q[$];   // {port, param}
    logic [31:0] ctl = '0;   // shadow of start and parameter bits

    always #10 clk = ~clk;

    bist_launch_ctrl i_bist_launch_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .dev_ready(dev_ready), .port_en(port_en),
        .launch_valid(launch_valid), .launch_port(launch_port),
        .launch_param(launch_param), .cpl_ok(cpl_ok), .cpl_err(cpl_err)
    );

    // Monitor: every launch must match the head of the expected queue (R3, R5)
    always @(negedge clk) begin
        if (rst_n && launch_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3/R4/R6/R10 unexpected launch: actual port=%0d param=%h, expected none",
                         launch_port, launch_param);
            end else begin
                logic [6:0] e;
                e = exp_q.pop_front();
                if ({launch_port, launch_param} != e) begin
                    fails++;
                    $display("FAIL R3/R5 launch: actual %h, expected %h",
                             {launch_port, launch_param}, e);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h, expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w1c);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = ctl | w1c;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic expect_launch(input logic port);
        exp_q.push_back({port, ctl[7:2]});
    endtask

    task automatic settle_check(input string req);
        @(negedge clk);
        check(req, exp_q.size(), 0);
    endtask

    task automatic complete(input logic ok);
        @(negedge clk);
        cpl_ok  = ok;
        cpl_err = ~ok;
        @(negedge clk);
        cpl_ok  = 1'b0;
        cpl_err = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset", reg_rd_data, 32'h0);

        // R3 R5: launch port 0 with parameters 0x2A
        ctl = (32'h2A << 2) | (1 << 8);
        expect_launch(0);
        wr(0);
        check("R5 param readback", reg_rd_data, ctl);
        settle_check("R3 launch port0");

        // R2: error completion
        complete(0);
        check("R2 err flag set", reg_rd_data[10], 1'b1);
        wr(1 << 10);   // steady start bit: no launch
        check("R2 err flag cleared", reg_rd_data[10], 1'b0);
        settle_check("R3 steady level no launch");

        // R7: retry after error
        ctl[8] = 1'b0; wr(0);
        ctl[8] = 1'b1; expect_launch(0); wr(0);
        settle_check("R7 retry launch");
        complete(1);
        check("R1 ok flag set", reg_rd_data[11], 1'b1);
        wr(1 << 11);
        check("R1 ok flag cleared", reg_rd_data[11], 1'b0);

        // R6: lockout after success
        ctl[8] = 1'b0; wr(0);
        ctl[8] = 1'b1; wr(0);
        settle_check("R6 locked port ignores edge");
        @(negedge clk); port_en[0] = 1'b0;
        @(negedge clk); port_en[0] = 1'b1;
        @(negedge clk);
        ctl[8] = 1'b0; wr(0);
        ctl[8] = 1'b1; expect_launch(0); wr(0);
        settle_check("R6 unlocked after enable toggle");
        complete(0);
        wr(1 << 10);

        // R4: not ready
        dev_ready[1] = 1'b0;
        ctl[9] = 1'b1; wr(0);
        settle_check("R4 not ready ignored");
        // R10: completion with nothing outstanding
        complete(1);
        check("R10 stray completion", reg_rd_data[11:10], 2'b00);
        dev_ready[1] = 1'b1;
        ctl[9] = 1'b0; wr(0);
        ctl[9] = 1'b1; ctl[7:2] = 6'h15; expect_launch(1); wr(0);
        settle_check("R3 launch port1");

        // R10: edge while pending ignored
        ctl[8] = 1'b0; wr(0);
        ctl[8] = 1'b1; wr(0);
        settle_check("R10 edge while pending");
        complete(1);
        check("R1 ok after port1", reg_rd_data[11], 1'b1);
        wr(1 << 11);

        // R9: set wins over W1C clear
        ctl[8] = 1'b0; wr(0);
        ctl[8] = 1'b1; expect_launch(0); wr(0);
        settle_check("R9 setup launch");
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = ctl | (1 << 10);
        cpl_err     = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        cpl_err   = 1'b0;
        check("R9 set wins", reg_rd_data[10], 1'b1);
        wr(1 << 10);

        // R8: reserved bits
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = 32'hFFFF_F003 | ctl;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R8 reserved read zero", reg_rd_data, ctl);
        settle_check("R8 no side launch");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule